// File: doc/BRIEF.md
# Positional Belt Operand Store

This block holds recent results in place of a register file. Producers push up to two new results into it each cycle. Each push goes in at the front, and every older entry moves back by the number of results pushed. Anything pushed past the last slot is lost. Consumers do not name a register. They name an age: position 0 is the newest value, position 1 the one before it, and so on. Every read port can pick any live position.

Each slot stores a data word and a small tag. The tag has a width code, a "no value" flag and a "deferred fault" flag. It has no type, so one stored word can feed integer or floating-point logic without change. A helper merges the tags of read ports 0 and 1 the way a two-operand operation would. This gives the tag a result should carry.

Reads are combinational and show the belt as it stood before the current cycle's pushes. An issuing instruction therefore binds its positions to the contents it saw.

Top module: `belt_operand_store`

## Requirements
- R1: A synchronous active-high reset makes every position read as no-value (none=1, nar=0, size code 00) with data zero.
- R2: During a cycle with pushes, reads return the contents from before that cycle's pushes. The new value is visible at position 0 from the following cycle.
- R3: A single push moves every older entry back by one position, and the entry in the last position (N-1) is discarded.
- R4: When both results are pushed together, result 0 lands at position 0, result 1 lands at position 1, and older entries move back by two.
- R5: When result 1 is pushed alone, it behaves as a single push and lands at position 0.
- R6: Each read port picks any position on its own, and two ports naming the same position return the same word.
- R7: Width code (00=8, 01=16, 10=32, 11=64 bits), none flag and nar flag come back exactly as pushed. The data word comes back unchanged whatever its code.
- R8: A position at or beyond the number of values pushed since reset reads as no-value with data zero. The count saturates at N.
- R9: The merged tag has nar=1 whenever either input tag has nar set.
- R10: Otherwise, the merged tag has none=1 if either input has none set. When nar=1, none reads 0.
- R11: The merged width code is always the larger of the two input codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res0_en | input | 1 | Push result 0 this cycle |
| res0_data | input | DW | Result 0 data |
| res0_size | input | 2 | Result 0 width code |
| res0_nar | input | 1 | Result 0 deferred-fault flag |
| res0_none | input | 1 | Result 0 no-value flag |
| res1_en | input | 1 | Push result 1 this cycle |
| res1_data | input | DW | Result 1 data |
| res1_size | input | 2 | Result 1 width code |
| res1_nar | input | 1 | Result 1 deferred-fault flag |
| res1_none | input | 1 | Result 1 no-value flag |
| rd_pos | input | NRD*PW | Position per read port, port k in bits [k*PW +: PW] |
| rd_data | output | NRD*DW | Data per read port |
| rd_size | output | NRD*2 | Width code per read port |
| rd_nar | output | NRD | Deferred-fault flag per read port |
| rd_none | output | NRD | No-value flag per read port |
| mrg_size | output | 2 | Merged width code of ports 0 and 1 |
| mrg_nar | output | 1 | Merged deferred-fault flag |
| mrg_none | output | 1 | Merged no-value flag |

## Verification
The hardest state to reach is a full belt whose oldest value has just been pushed out. Reaching it means mixing single pushes, paired pushes and a lone push of result 1 until more than N values have gone in. The stimulus does exactly that. After every push it reads all positions through both ports, each port walking in the opposite direction, and compares them with a shifting-queue model. Merge precedence is driven by a table of paired pushes whose tags cover every fault and no-value combination.

// File: rtl/belt_pkg.sv
package belt_pkg;

   // Width code of a stored operand
   localparam logic [1:0] SZ_B8  = 2'b00;
   localparam logic [1:0] SZ_B16 = 2'b01;
   localparam logic [1:0] SZ_B32 = 2'b10;
   localparam logic [1:0] SZ_B64 = 2'b11;

   typedef struct packed {
      logic       nar;
      logic       none;
      logic [1:0] size;
   } belt_meta_t;

   localparam belt_meta_t META_EMPTY = '{nar: 1'b0, none: 1'b1, size: SZ_B8};

endpackage

// File: rtl/belt_meta_merge.sv
module belt_meta_merge
   import belt_pkg::*;
(
   input  belt_meta_t a_meta,
   input  belt_meta_t b_meta,
   output belt_meta_t y_meta
);

   logic any_nar;
   logic any_none;

   assign any_nar  = a_meta.nar | b_meta.nar;
   assign any_none = a_meta.none | b_meta.none;

   always_comb begin
      y_meta.nar  = any_nar;
      y_meta.none = ~any_nar & any_none;
      y_meta.size = (a_meta.size > b_meta.size) ? a_meta.size : b_meta.size;
   end

endmodule

// File: rtl/belt_read_port.sv
module belt_read_port
   import belt_pkg::*;
#(
   parameter int N    = 8,
   parameter int DW   = 64,
   parameter int PW   = $clog2(N),
   parameter int DEPW = $clog2(N + 1)
) (
   input  logic [PW-1:0]           pos,
   input  logic [N-1:0][DW-1:0]    ent_data,
   input  belt_meta_t [N-1:0]      ent_meta,
   input  logic [DEPW-1:0]         depth,
   output logic [DW-1:0]           out_data,
   output belt_meta_t              out_meta
);

   logic live;

   assign live = DEPW'(pos) < depth;

   always_comb begin
      if (live) begin
         out_data = ent_data[pos];
         out_meta = ent_meta[pos];
      end else begin
         out_data = '0;
         out_meta = META_EMPTY;
      end
   end

endmodule

// File: rtl/belt_store.sv
module belt_store
   import belt_pkg::*;
#(
   parameter int N    = 8,
   parameter int DW   = 64,
   parameter int DEPW = $clog2(N + 1)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    ins0_en,
   input  logic [DW-1:0]           ins0_data,
   input  belt_meta_t              ins0_meta,
   input  logic                    ins1_en,
   input  logic [DW-1:0]           ins1_data,
   input  belt_meta_t              ins1_meta,
   output logic [N-1:0][DW-1:0]    ent_data,
   output belt_meta_t [N-1:0]      ent_meta,
   output logic [DEPW-1:0]         depth
);

   localparam int SW = DEPW + 1;

   logic [1:0]      ins_n;
   logic [DW-1:0]   first_data;
   belt_meta_t      first_meta;
   logic [SW-1:0]   depth_sum;

   assign ins_n      = {1'b0, ins0_en} + {1'b0, ins1_en};
   assign first_data = ins0_en ? ins0_data : ins1_data;
   assign first_meta = ins0_en ? ins0_meta : ins1_meta;
   assign depth_sum  = {1'b0, depth} + SW'(ins_n);

   always_ff @(posedge clk) begin
      if (rst)
         depth <= '0;
      else if (depth_sum > SW'(N))
         depth <= DEPW'(N);
      else
         depth <= depth_sum[DEPW-1:0];
   end

   for (genvar i = 0; i < N; i++) begin : g_slot
      logic [DW-1:0] nd_one;
      logic [DW-1:0] nd_two;
      belt_meta_t    nm_one;
      belt_meta_t    nm_two;

      if (i == 0) begin : g_front
         assign nd_one = first_data;
         assign nm_one = first_meta;
         assign nd_two = first_data;
         assign nm_two = first_meta;
      end else if (i == 1) begin : g_second
         assign nd_one = ent_data[0];
         assign nm_one = ent_meta[0];
         assign nd_two = ins1_data;
         assign nm_two = ins1_meta;
      end else begin : g_back
         assign nd_one = ent_data[i-1];
         assign nm_one = ent_meta[i-1];
         assign nd_two = ent_data[i-2];
         assign nm_two = ent_meta[i-2];
      end

      always_ff @(posedge clk) begin
         if (rst) begin
            ent_data[i] <= '0;
            ent_meta[i] <= META_EMPTY;
         end else begin
            case (ins_n)
               2'd1: begin
                  ent_data[i] <= nd_one;
                  ent_meta[i] <= nm_one;
               end
               2'd2: begin
                  ent_data[i] <= nd_two;
                  ent_meta[i] <= nm_two;
               end
               default: ;
            endcase
         end
      end
   end

   // R1
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> (depth == '0) && ent_meta[N-1].none && (ent_data[0] == '0));

   // R3
   shift_one_chk: assert property (@(posedge clk) disable iff (rst)
      (ins_n == 2'd1) |=> (ent_data[N-1] == $past(ent_data[N-2]))
                          && (ent_meta[1] == $past(ent_meta[0])));

   // R4
   shift_two_chk: assert property (@(posedge clk) disable iff (rst)
      (ins_n == 2'd2) |=> (ent_data[2] == $past(ent_data[0]))
                          && (ent_meta[N-1] == $past(ent_meta[N-3])));

   // R8
   depth_cap_chk: assert property (@(posedge clk) disable iff (rst)
      depth <= DEPW'(N));

   // R2
   hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (ins_n == 2'd0) |=> $stable(ent_data) && $stable(depth));

endmodule

// File: rtl/belt_operand_store.sv
module belt_operand_store
   import belt_pkg::*;
#(
   parameter int N   = 8,
   parameter int DW  = 64,
   parameter int NRD = 2,
   parameter int PW  = $clog2(N)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                res0_en,
   input  logic [DW-1:0]       res0_data,
   input  logic [1:0]          res0_size,
   input  logic                res0_nar,
   input  logic                res0_none,
   input  logic                res1_en,
   input  logic [DW-1:0]       res1_data,
   input  logic [1:0]          res1_size,
   input  logic                res1_nar,
   input  logic                res1_none,
   input  logic [NRD*PW-1:0]   rd_pos,
   output logic [NRD*DW-1:0]   rd_data,
   output logic [NRD*2-1:0]    rd_size,
   output logic [NRD-1:0]      rd_nar,
   output logic [NRD-1:0]      rd_none,
   output logic [1:0]          mrg_size,
   output logic                mrg_nar,
   output logic                mrg_none
);

   localparam int DEPW = $clog2(N + 1);

   if (N < 3) begin : g_bad_len
      $error("belt_operand_store: N must be at least 3");
   end
   if (NRD < 2) begin : g_bad_ports
      $error("belt_operand_store: NRD must be at least 2");
   end
   if (DW < 8) begin : g_bad_width
      $error("belt_operand_store: DW must be at least 8");
   end

   logic [N-1:0][DW-1:0] ent_data;
   belt_meta_t [N-1:0]   ent_meta;
   logic [DEPW-1:0]      depth;
   belt_meta_t           in0_meta;
   belt_meta_t           in1_meta;
   belt_meta_t [NRD-1:0] rm;
   belt_meta_t           mm;
   logic [NRD-1:0][DW-1:0] rdd;

   assign in0_meta = '{nar: res0_nar, none: res0_none, size: res0_size};
   assign in1_meta = '{nar: res1_nar, none: res1_none, size: res1_size};

   belt_store #(.N(N), .DW(DW), .DEPW(DEPW)) i_store (
      .clk       (clk),
      .rst       (rst),
      .ins0_en   (res0_en),
      .ins0_data (res0_data),
      .ins0_meta (in0_meta),
      .ins1_en   (res1_en),
      .ins1_data (res1_data),
      .ins1_meta (in1_meta),
      .ent_data  (ent_data),
      .ent_meta  (ent_meta),
      .depth     (depth)
   );

   for (genvar k = 0; k < NRD; k++) begin : g_rd
      belt_read_port #(.N(N), .DW(DW), .PW(PW), .DEPW(DEPW)) i_port (
         .pos      (rd_pos[k*PW +: PW]),
         .ent_data (ent_data),
         .ent_meta (ent_meta),
         .depth    (depth),
         .out_data (rdd[k]),
         .out_meta (rm[k])
      );
      assign rd_data[k*DW +: DW] = rdd[k];
      assign rd_size[k*2 +: 2]   = rm[k].size;
      assign rd_nar[k]           = rm[k].nar;
      assign rd_none[k]          = rm[k].none;
   end

   belt_meta_merge i_merge (
      .a_meta (rm[0]),
      .b_meta (rm[1]),
      .y_meta (mm)
   );

   assign mrg_size = mm.size;
   assign mrg_nar  = mm.nar;
   assign mrg_none = mm.none;

   // R9
   merge_nar_chk: assert property (@(posedge clk) disable iff (rst)
      (rm[0].nar || rm[1].nar) |-> mrg_nar && !mrg_none);

   // R10
   merge_none_chk: assert property (@(posedge clk) disable iff (rst)
      (!rm[0].nar && !rm[1].nar && (rm[0].none || rm[1].none)) |-> mrg_none);

   // R11
   merge_size_chk: assert property (@(posedge clk) disable iff (rst)
      (mrg_size >= rm[0].size) && (mrg_size >= rm[1].size));

   // R6
   same_pos_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_pos[0 +: PW] == rd_pos[PW +: PW]) |-> (rdd[0] == rdd[1]) && (rm[0] == rm[1]));

   // R8
   empty_read_chk: assert property (@(posedge clk) disable iff (rst)
      (depth == '0) |-> rm[0].none && (rdd[0] == '0));

endmodule

// File: tb/test_belt_operand_store.sv
`timescale 1ns/1ps
module test_belt_operand_store;

   localparam int N  = 8;
   localparam int DW = 64;
   localparam int PW = 3;

   // each row: {res0 meta, res1 meta, expected merge}, meta = {nar, none, size[1:0]}
   localparam logic [11:0] MRG_TAB [8] = '{
      12'h212, 12'h033, 12'h83B, 12'h589,
      12'h637, 12'h145, 12'hC08, 12'h333
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic res0_en = 1'b0, res1_en = 1'b0;
   logic [DW-1:0] res0_data = '0, res1_data = '0;
   logic [1:0] res0_size = '0, res1_size = '0;
   logic res0_nar = 1'b0, res0_none = 1'b0, res1_nar = 1'b0, res1_none = 1'b0;
   logic [2*PW-1:0] rd_pos = '0;
   logic [2*DW-1:0] rd_data;
   logic [3:0] rd_size;
   logic [1:0] rd_nar, rd_none;
   logic [1:0] mrg_size;
   logic mrg_nar, mrg_none;

   int total = 0;
   int bad = 0;
   logic done = 1'b0;

   logic [DW-1:0] m_data [N];
   logic [3:0]    m_meta [N];
   int            m_depth;

   always #2 clk = ~clk;

   belt_operand_store #(.N(N), .DW(DW), .NRD(2)) i_belt_operand_store (
      .clk(clk), .rst(rst),
      .res0_en(res0_en), .res0_data(res0_data), .res0_size(res0_size),
      .res0_nar(res0_nar), .res0_none(res0_none),
      .res1_en(res1_en), .res1_data(res1_data), .res1_size(res1_size),
      .res1_nar(res1_nar), .res1_none(res1_none),
      .rd_pos(rd_pos), .rd_data(rd_data), .rd_size(rd_size),
      .rd_nar(rd_nar), .rd_none(rd_none),
      .mrg_size(mrg_size), .mrg_nar(mrg_nar), .mrg_none(mrg_none)
   );

   task automatic model_clear();
      for (int i = 0; i < N; i++) begin
         m_data[i] = '0;
         m_meta[i] = 4'b0100;
      end
      m_depth = 0;
   endtask

   task automatic exp_at(input int p, output logic [DW-1:0] d, output logic [3:0] m);
      if (p < m_depth) begin
         d = m_data[p];
         m = m_meta[p];
      end else begin
         d = '0;
         m = 4'b0100;
      end
   endtask

   task automatic check_port(input int k, input int p, input string tag);
      logic [DW-1:0] ed, ad;
      logic [3:0] em, am;
      exp_at(p, ed, em);
      ad = rd_data[k*DW +: DW];
      am = {rd_nar[k], rd_none[k], rd_size[k*2 +: 2]};
      total++;
      if (ad !== ed || am !== em) begin
         bad++;
         $display("FAIL %s port %0d pos %0d data %h exp %h meta %b exp %b",
                  tag, k, p, ad, ed, am, em);
      end
   endtask

   // reads every position on both ports, port 1 walking backwards (R6, R7)
   task automatic check_all(input string tag);
      for (int p = 0; p < N; p++) begin
         rd_pos = {PW'(N - 1 - p), PW'(p)};
         #0.2;
         check_port(0, p, tag);
         check_port(1, N - 1 - p, tag);
      end
   endtask

   task automatic push(input logic e0, input logic [DW-1:0] d0, input logic [3:0] m0,
                       input logic e1, input logic [DW-1:0] d1, input logic [3:0] m1,
                       input string tag);
      int cnt;
      logic [DW-1:0] fd;
      logic [3:0] fm;
      @(negedge clk);
      res0_en = e0; res0_data = d0; {res0_nar, res0_none, res0_size} = m0;
      res1_en = e1; res1_data = d1; {res1_nar, res1_none, res1_size} = m1;
      rd_pos = {PW'(1), PW'(0)};
      #0.2;
      check_port(0, 0, "R2");   // old contents before the edge
      check_port(1, 1, "R2");
      @(negedge clk);
      res0_en = 1'b0;
      res1_en = 1'b0;
      cnt = int'(e0) + int'(e1);
      fd = e0 ? d0 : d1;
      fm = e0 ? m0 : m1;
      if (cnt > 0) begin
         for (int i = N - 1; i >= cnt; i--) begin
            m_data[i] = m_data[i-cnt];
            m_meta[i] = m_meta[i-cnt];
         end
         m_data[0] = fd;
         m_meta[0] = fm;
         if (cnt == 2) begin
            m_data[1] = d1;
            m_meta[1] = m1;
         end
         m_depth = (m_depth + cnt > N) ? N : m_depth + cnt;
      end
      check_all(tag);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check_all("R1");   // also R8: nothing pushed yet

      // table walk: paired pushes, merge of positions 0 and 1 (R9, R10, R11, R7)
      for (int r = 0; r < 8; r++) begin
         logic [11:0] row;
         logic [3:0] em, am;
         string tg;
         row = MRG_TAB[r];
         push(1'b1, 64'hA000_0000_0000_0000 | 64'(r), row[11:8],
              1'b1, 64'h0B00_0000_0000_00F0 | 64'(r), row[7:4], "R4");
         rd_pos = {PW'(1), PW'(0)};
         #0.2;
         em = row[3:0];
         am = {mrg_nar, mrg_none, mrg_size};
         tg = em[3] ? "R9" : (em[2] ? "R10" : "R11");
         total++;
         if (am !== em) begin
            bad++;
            $display("FAIL %s merge row %0d meta %b exp %b", tg, r, am, em);
         end
      end

      // R1 again mid-run
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      model_clear();
      check_all("R1");

      // single pushes with varied tags (R3, R7, R8)
      push(1'b1, 64'h1111_2222_3333_4444, 4'b0011, 1'b0, '0, 4'b0000, "R8");
      push(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 4'b1001, 1'b0, '0, 4'b0000, "R7");
      push(1'b1, 64'h0000_0000_0000_00AB, 4'b0100, 1'b0, '0, 4'b0000, "R3");
      // paired (R4)
      push(1'b1, 64'h5555, 4'b0010, 1'b1, 64'h6666, 4'b0001, "R4");
      // lone result 1 (R5)
      push(1'b0, 64'hDEAD, 4'b0011, 1'b1, 64'hBEEF_0000_0000_0001, 4'b0010, "R5");
      // overflow: oldest discarded (R3, R4)
      push(1'b1, 64'h7777, 4'b0000, 1'b1, 64'h8888, 4'b0011, "R4");
      for (int j = 0; j < 4; j++)
         push(1'b1, 64'hC0DE_0000 + 64'(j), 4'(j), 1'b0, '0, 4'b0000, "R3");
      // idle cycle: nothing changes (R2)
      push(1'b0, 64'h9999, 4'b0011, 1'b0, 64'h9999, 4'b0011, "R2");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule